// File: doc/BRIEF.md
# I2C Shadow Register Target

This block is an I2C target that gives an I2C controller read and write access to a bank of 128 shadow registers, each 8 bits wide. The raw SCL and SDA pins pass through a two-flop synchronizer and a three-sample agreement filter inside the block. The filtered lines feed an edge detector that reports START, repeated START, STOP and SCL edges. SDA is driven open-drain: `sda_oe` high pulls the line low.

A frame opens with the device byte: seven address bits followed by the direction bit. The block answers only to device address 7'b0010000, which is byte 0x20 to write and 0x21 to read. In a write frame, the next byte sets the access mode in bit 7 (1 = block, 0 = single) and loads the register pointer from bits 6:0. Any further bytes are written to the bank. A read frame returns bytes from the stored pointer. The usual pattern is a write frame that carries only the mode/pointer byte, followed by a repeated START and the read address. In block mode the pointer steps after every byte and wraps from 0x7F to 0x00. In single mode the pointer stays put. The bank is reached through a small synchronous port. Each write is a one-cycle strobe with address and data. Each read is a one-cycle strobe, and the bank's data is taken in that same cycle.

The controller is a single state machine:

| State | Role |
|---|---|
| ST_IDLE | Waits for START. |
| ST_DEV | Shifts in the device byte. |
| ST_DEV_ACK | Drives the acknowledge for the device byte. |
| ST_PTR | Shifts in the mode/pointer byte. |
| ST_PTR_ACK | Drives the acknowledge for the mode/pointer byte. |
| ST_WDATA | Shifts in a write data byte. |
| ST_WDATA_ACK | Acknowledge slot of a write data byte. The block drives ACK only when that byte was stored. |
| ST_RDATA | Drives a read byte, MSB first. |
| ST_RACK | Samples the controller's acknowledge. |
| ST_SKIP | Stays off the bus until the next START or STOP. |

Transitions:
- STOP moves any state to ST_IDLE.
- START moves any state to ST_DEV.
- ST_DEV goes to ST_DEV_ACK on an address match, and to ST_SKIP otherwise.
- ST_DEV_ACK goes to ST_RDATA for a read and to ST_PTR for a write.
- ST_PTR goes to ST_PTR_ACK.
- ST_PTR_ACK goes to ST_WDATA.
- ST_WDATA and ST_WDATA_ACK alternate.
- ST_RDATA goes to ST_RACK.
- ST_RACK goes back to ST_RDATA on ACK, and to ST_SKIP on NACK.

Every move out of a bit or acknowledge state happens on a filtered SCL falling edge.

Top module: `shreg_i2c_target`

## Requirements
- R1: While reset is held, `sda_oe`, `reg_we` and `reg_re` are all low.
- R2: The block acknowledges a device byte of 0x20 or 0x21 (address 7'b0010000 in bits 7:1, direction in bit 0, 1 = read). It NACKs any other device byte and makes no bank access in that frame.
- R3: The second byte of a write frame is acknowledged. Its bit 7 selects block (1) or single (0) mode, and its bits 6:0 load the register pointer.
- R4: In single mode, the first data byte of a write frame is written at the pointer and acknowledged. Every later data byte in that frame is NACKed and not written. Each write strobe lasts one cycle.
- R5: In block mode, every data byte is written at the pointer and acknowledged, and the pointer then advances by one, wrapping from 0x7F to 0x00.
- R6: The mode and the pointer are kept across a repeated START and across STOP, and only reset clears them. A read frame that follows a pointer-only write frame returns data from that pointer.
- R7: A single-mode read returns the byte at the pointer, MSB first, and does not advance the pointer.
- R8: A block-mode read returns consecutive registers, wrapping from 0x7F to 0x00, for as long as the controller acknowledges. After a NACK the block releases SDA.
- R9: STOP at any point, including in the middle of a byte, ends the transfer. The block returns to idle with SDA released and writes no partial byte. The pointer is left unchanged.
- R10: A pulse on SCL that lasts fewer than three clock cycles is ignored.
- R11: Each read byte comes from exactly one single-cycle `reg_re` strobe, with `reg_rdata` taken in that cycle. `reg_re` and `reg_we` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL pin level |
| sda_i | input | 1 | Raw SDA pin level |
| sda_oe | output | 1 | Pulls SDA low when high (open drain) |
| reg_addr | output | 7 | Bank register address |
| reg_wdata | output | 8 | Bank write data |
| reg_we | output | 1 | One-cycle bank write strobe |
| reg_re | output | 1 | One-cycle bank read strobe |
| reg_rdata | input | 8 | Bank read data, valid while `reg_re` is high |

## Verification
A change on a pin reaches the state machine about seven cycles later: two synchronizer flops, three filter samples, the filter output flop and the edge register. The acknowledge drive, the next read bit, and the `reg_we` or `reg_re` strobe all rise one cycle after that filtered SCL fall. The bench therefore holds each SCL phase for at least twenty clocks. It samples SDA fourteen clocks after raising SCL, well after the block's response has settled. A behavioural model keeps a queue of expected bank writes and a shadow copy of the registers. Every clock, any `reg_we` is compared with the head of that queue, which makes the write checks independent of exact strobe timing.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } tgt_state_e;

endpackage

// File: rtl/shreg_line_cond.sv
// Synchronizer followed by an agreement filter: the clean level only
// changes once FILT_LEN consecutive synchronized samples agree.
module shreg_line_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;
    logic                   clean_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '1;
            hist_q  <= '1;
            clean_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q)
                clean_q <= 1'b1;
            else if (~|hist_q)
                clean_q <= 1'b0;
        end
    end

    assign clean_o = clean_q;

endmodule

// File: rtl/shreg_bus_events.sv
// Edge and bus-condition detector on the filtered lines.
module shreg_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_c,
    input  logic sda_c,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_c;
            sda_d <= sda_c;
        end
    end

    assign scl_rise = scl_c & ~scl_d;
    assign scl_fall = ~scl_c & scl_d;
    assign start_ev = scl_c & scl_d & sda_d & ~sda_c;
    assign stop_ev  = scl_c & scl_d & ~sda_d & sda_c;

endmodule

// File: rtl/shreg_i2c_target.sv
module shreg_i2c_target
    import shreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b0010000,
    parameter int         DW          = 8,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic [DW-2:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    input  logic [DW-1:0] reg_rdata
);

    localparam int AW = DW - 1;
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] BITS = CW'(DW);

    // ---------------- line conditioning ----------------
    logic [1:0] raw_w, cln_w;
    assign raw_w = {scl_i, sda_i};

    for (genvar gi = 0; gi < 2; gi++) begin : g_line
        shreg_line_cond #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_cond (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_w[gi]),
            .clean_o(cln_w[gi])
        );
    end

    logic scl_c, sda_c;
    assign scl_c = cln_w[1];
    assign sda_c = cln_w[0];

    logic scl_rise, scl_fall, start_ev, stop_ev;

    shreg_bus_events u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_c   (scl_c),
        .sda_c   (sda_c),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_ev(start_ev),
        .stop_ev (stop_ev)
    );

    // ---------------- state ----------------
    tgt_state_e    st, st_nx;
    logic [CW-1:0] bit_cnt;
    logic [DW-1:0] sh_q, tx_q, wdata_q;
    logic [AW-1:0] ptr_q, addr_q;
    logic          blk_q, first_q, rd_q, mack_q, ack_q, we_q, re_q;

    logic byte_done, dev_hit;
    assign byte_done = (bit_cnt == BITS);
    assign dev_hit   = (sh_q[DW-1:1] == DEV_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (stop_ev)
            st_nx = ST_IDLE;
        else if (start_ev)
            st_nx = ST_DEV;
        else begin
            unique case (st)
                ST_IDLE:      st_nx = ST_IDLE;
                ST_DEV:       if (scl_fall && byte_done) st_nx = dev_hit ? ST_DEV_ACK : ST_SKIP;
                ST_DEV_ACK:   if (scl_fall) st_nx = rd_q ? ST_RDATA : ST_PTR;
                ST_PTR:       if (scl_fall && byte_done) st_nx = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall) st_nx = ST_WDATA;
                ST_WDATA:     if (scl_fall && byte_done) st_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) st_nx = ST_WDATA;
                ST_RDATA:     if (scl_fall && byte_done) st_nx = ST_RACK;
                ST_RACK:      if (scl_fall) st_nx = mack_q ? ST_RDATA : ST_SKIP;
                ST_SKIP:      st_nx = ST_SKIP;
                default:      st_nx = ST_IDLE;
            endcase
        end
    end

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            sh_q    <= '0;
            tx_q    <= '1;
            wdata_q <= '0;
            ptr_q   <= '0;
            addr_q  <= '0;
            blk_q   <= 1'b0;
            first_q <= 1'b0;
            rd_q    <= 1'b0;
            mack_q  <= 1'b0;
            ack_q   <= 1'b0;
            we_q    <= 1'b0;
            re_q    <= 1'b0;
        end else begin
            we_q <= 1'b0;
            re_q <= 1'b0;
            if (stop_ev || start_ev) begin
                bit_cnt <= '0;
                ack_q   <= 1'b0;
            end else begin
                unique case (st)
                    ST_DEV, ST_PTR, ST_WDATA: begin
                        if (scl_rise) begin
                            sh_q    <= {sh_q[DW-2:0], sda_c};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (scl_fall && byte_done) begin
                            bit_cnt <= '0;
                            if (st == ST_DEV) begin
                                rd_q <= sh_q[0];
                                if (dev_hit) begin
                                    ack_q <= 1'b1;
                                    if (sh_q[0]) begin
                                        re_q   <= 1'b1;
                                        addr_q <= ptr_q;
                                    end
                                end
                            end else if (st == ST_PTR) begin
                                blk_q   <= sh_q[DW-1];
                                ptr_q   <= sh_q[AW-1:0];
                                ack_q   <= 1'b1;
                                first_q <= 1'b1;
                            end else begin
                                first_q <= 1'b0;
                                if (blk_q || first_q) begin
                                    ack_q   <= 1'b1;
                                    we_q    <= 1'b1;
                                    addr_q  <= ptr_q;
                                    wdata_q <= sh_q;
                                    if (blk_q) ptr_q <= ptr_q + 1'b1;
                                end
                            end
                        end
                    end
                    ST_DEV_ACK, ST_PTR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) ack_q <= 1'b0;
                    end
                    ST_RDATA: begin
                        if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
                        if (scl_fall) begin
                            if (byte_done) begin
                                bit_cnt <= '0;
                                if (blk_q) ptr_q <= ptr_q + 1'b1;
                            end else begin
                                tx_q <= {tx_q[DW-2:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) mack_q <= ~sda_c;
                        if (scl_fall && mack_q) begin
                            re_q   <= 1'b1;
                            addr_q <= ptr_q;
                        end
                    end
                    default: ;
                endcase
            end
            if (re_q) tx_q <= reg_rdata;
        end
    end

    assign sda_oe    = ack_q | ((st == ST_RDATA) & ~tx_q[DW-1]);
    assign reg_addr  = addr_q;
    assign reg_wdata = wdata_q;
    assign reg_we    = we_q;
    assign reg_re    = re_q;

endmodule

// File: rtl/shreg_i2c_target_chk.sv
module shreg_i2c_target_chk
    import shreg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input tgt_state_e st,
    input logic       start_ev,
    input logic       stop_ev,
    input logic       sda_oe,
    input logic       reg_we,
    input logic       reg_re
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re)); // R11

    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R4

    AST_WE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> sda_oe); // R5

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (st == ST_IDLE && !sda_oe)); // R9

    AST_START_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (st == ST_DEV)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe); // R9

endmodule

bind shreg_i2c_target shreg_i2c_target_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .start_ev(start_ev),
    .stop_ev (stop_ev),
    .sda_oe  (sda_oe),
    .reg_we  (reg_we),
    .reg_re  (reg_re)
);

// File: tb/sim_shreg_i2c_target.sv
`timescale 1ns/1ps
module sim_shreg_i2c_target;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we, reg_re;
    logic [7:0] reg_rdata;
    wire        sda_line = sda_m & ~sda_oe;

    logic [7:0]  mem   [128];
    logic [7:0]  ref_m [128];
    logic [14:0] wq [$];
    int total = 0, fails = 0, cyc = 0, re_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign reg_rdata = mem[reg_addr];

    shreg_i2c_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    // bank model and write monitor, compared on every clock
    always @(negedge clk) begin
        cyc++;
        if (rst_n && reg_re) re_cnt++;
        if (rst_n && reg_we) begin
            if (wq.size() == 0) begin
                total++; fails++;
                $display("FAIL R4 unexpected write actual=%0h/%0h expected=none", reg_addr, reg_wdata);
            end else begin
                logic [14:0] e;
                e = wq.pop_front();
                chk({reg_addr, reg_wdata} == e, "R5 write addr/data", {reg_addr, reg_wdata}, e);
            end
            mem[reg_addr] = reg_wdata;
        end
        if (cyc > 190000 && !done) begin
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected<190000", cyc);
            finish_run();
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(20);
        scl_m = 1'b1; wt(20);
        sda_m = 1'b0; wt(20);
        scl_m = 1'b0; wt(10);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(10);
        scl_m = 1'b1; wt(20);
        sda_m = 1'b1; wt(20);
    endtask

    task automatic send_bit(input bit b, input bit glitch);
        wt(10);
        sda_m = b;
        if (glitch) begin
            wt(4); scl_m = 1'b1; wt(2); scl_m = 1'b0; wt(4);
        end else begin
            wt(10);
        end
        scl_m = 1'b1; wt(20);
        scl_m = 1'b0;
    endtask

    task automatic recv_bit(output bit b);
        sda_m = 1'b1; wt(20);
        scl_m = 1'b1; wt(14);
        b = sda_line; wt(6);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, input int gbit, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) send_bit(v[i], i == gbit);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input bit do_ack, output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~do_ack, 1'b0);
    endtask

    initial begin
        bit ack;
        logic [7:0] d;
        int re0;
        for (int i = 0; i < 128; i++) begin
            mem[i]   = 8'(i * 7 + 3);
            ref_m[i] = 8'(i * 7 + 3);
        end
        wt(5);
        chk(!sda_oe && !reg_we && !reg_re, "R1 reset outputs", {sda_oe, reg_we, reg_re}, 0);
        rst_n = 1'b1;
        wt(20);

        // R2: foreign device address
        bus_start(); send_byte(8'h44, -1, ack);
        chk(!ack, "R2 foreign address NACK", ack, 0);
        bus_stop();

        // R3/R4: single write, extra byte refused
        bus_start(); send_byte(8'h20, -1, ack);
        chk(ack, "R2 write address ACK", ack, 1);
        send_byte(8'h05, -1, ack);
        chk(ack, "R3 mode byte ACK", ack, 1);
        wq.push_back({7'h05, 8'hA5}); ref_m[5] = 8'hA5;
        send_byte(8'hA5, -1, ack);
        chk(ack, "R4 first data ACK", ack, 1);
        send_byte(8'h3C, -1, ack);
        chk(!ack, "R4 extra byte NACK", ack, 0);
        bus_stop();

        // R5: block write with wrap
        bus_start(); send_byte(8'h20, -1, ack);
        send_byte(8'hFE, -1, ack);
        chk(ack, "R3 block mode byte ACK", ack, 1);
        wq.push_back({7'h7E, 8'h11}); ref_m[7'h7E] = 8'h11;
        wq.push_back({7'h7F, 8'h22}); ref_m[7'h7F] = 8'h22;
        wq.push_back({7'h00, 8'h33}); ref_m[0]     = 8'h33;
        send_byte(8'h11, -1, ack); chk(ack, "R5 block byte0 ACK", ack, 1);
        send_byte(8'h22, -1, ack); chk(ack, "R5 block byte1 ACK", ack, 1);
        send_byte(8'h33, -1, ack); chk(ack, "R5 block byte2 ACK", ack, 1);
        bus_stop();

        // R6/R7/R11: pointer setup then repeated START single read
        bus_start(); send_byte(8'h20, -1, ack); send_byte(8'h05, -1, ack);
        re0 = re_cnt;
        bus_start(); send_byte(8'h21, -1, ack);
        chk(ack, "R6 read address ACK after repeated START", ack, 1);
        recv_byte(1'b0, d);
        chk(d == ref_m[5], "R6 read from stored pointer", d, ref_m[5]);
        bus_stop();
        chk(re_cnt - re0 == 1, "R11 one read strobe per byte", re_cnt - re0, 1);
        bus_start(); send_byte(8'h21, -1, ack);
        recv_byte(1'b1, d);
        chk(d == ref_m[5], "R7 single read first", d, ref_m[5]);
        recv_byte(1'b0, d);
        chk(d == ref_m[5], "R7 pointer not advanced", d, ref_m[5]);
        bus_stop();

        // R8: block read wrapping, released after NACK
        bus_start(); send_byte(8'h20, -1, ack); send_byte(8'hFF, -1, ack);
        bus_start(); send_byte(8'h21, -1, ack);
        recv_byte(1'b1, d); chk(d == ref_m[7'h7F], "R8 block read 7F", d, ref_m[7'h7F]);
        recv_byte(1'b1, d); chk(d == ref_m[0],     "R8 block read wrap 00", d, ref_m[0]);
        recv_byte(1'b0, d); chk(d == ref_m[1],     "R8 block read 01", d, ref_m[1]);
        wt(15);
        chk(!sda_oe, "R8 SDA released after NACK", sda_oe, 0);
        bus_stop();

        // R9: STOP in the middle of a data byte
        bus_start(); send_byte(8'h20, -1, ack); send_byte(8'h90, -1, ack);
        send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0);
        bus_stop(); wt(10);
        chk(!sda_oe, "R9 idle after STOP", sda_oe, 0);
        bus_start(); send_byte(8'h21, -1, ack);
        recv_byte(1'b0, d);
        chk(d == ref_m[7'h10], "R9 pointer kept, no partial write", d, ref_m[7'h10]);
        bus_stop();

        // R10: short SCL pulse during a data bit
        bus_start(); send_byte(8'h20, -1, ack); send_byte(8'h30, -1, ack);
        wq.push_back({7'h30, 8'h5C}); ref_m[7'h30] = 8'h5C;
        send_byte(8'h5C, 4, ack);
        chk(ack, "R10 byte with glitch ACK", ack, 1);
        bus_stop();
        bus_start(); send_byte(8'h21, -1, ack);
        recv_byte(1'b0, d);
        chk(d == 8'h5C, "R10 glitch ignored", d, 8'h5C);
        bus_stop();

        // R2/R11: foreign read address, no access
        re0 = re_cnt;
        bus_start(); send_byte(8'h23, -1, ack);
        chk(!ack, "R2 foreign read NACK", ack, 0);
        bus_stop();
        chk(re_cnt == re0, "R11 no read strobe on foreign address", re_cnt - re0, 0);

        wt(20);
        chk(wq.size() == 0, "R5 all expected writes seen", wq.size(), 0);
        finish_run();
    end

endmodule